// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sits beside the processor core and takes over when the core signals that it has executed a stop instruction. On that strobe it samples five configuration bits: stop enable, debug enable, low-voltage detect enable, low-voltage detect kept in stop, and partial power-down select. With stop disabled, it pulses an illegal-opcode reset request and stays in run. Otherwise a priority decode picks a shallow, state-retaining stop or a deep stop. Debug has the highest priority, then low-voltage detect. Either of them silently turns a deep request into a shallow one.

While stopped, the block gates the bus and CPU clock enables. It keeps the debug clock enable and the regulator-active output on only where the chosen mode needs them. The shallow stop ends on the reset pin request or on any enabled wakeup interrupt. The deep stop ends only on the reset pin request or on a dedicated wake input. Every exit passes through one restore cycle in which the clocks are already enabled. The block then returns to run and pulses an exit strobe with the cause, the index of the waking source, and a flag that tells whether state was lost in deep stop.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A stop strobe with stop enable low raises `illegal_rst` for exactly one cycle, in the cycle after the strobe edge. The state stays run (`stop_state`=0) and the clock enables stay high.
- R2: With stop enable and debug enable both high, the block enters shallow stop (`stop_state`=1) whatever the other bits are. `dbg_clk_en` and `vreg_active` stay high in that stop.
- R3: With debug low and both low-voltage bits high, the block enters shallow stop with `vreg_active` high, even when deep select is 1.
- R4: With debug low and either low-voltage bit low, deep select 0 gives shallow stop with `vreg_active` low, and deep select 1 gives deep stop (`stop_state`=2) with `vreg_active` low.
- R5: In shallow or deep stop, `bus_clk_en` and `cpu_clk_en` are low, and `dbg_clk_en` is low unless the stop was entered with debug enabled.
- R6: In shallow stop, a wakeup line exits only when its mask bit is 1. The exit reports cause IRQ (`exit_cause`=1) and, in `exit_src`, the lowest set index of `wake_irq & wake_mask`. Index 0 has the highest priority.
- R7: `pin_rst` exits either stop state with cause RESET (`exit_cause`=0). It takes priority over wakeup lines and over `deep_wake`.
- R8: Deep stop ignores the wakeup lines. `deep_wake` exits it with cause DEEPWAKE (`exit_cause`=2). `deep_wake` has no effect in shallow stop. Every exit from deep stop sets `deep_exit_flag` with the strobe, and every shallow exit clears it.
- R9: The edge that accepts a wake moves the block to the restore state (`stop_state`=3). In that state the clock enables are high and `exit_strobe` is low. The next edge returns to run with `exit_strobe` high for one cycle.
- R10: Configuration inputs that change during a stop do not alter the stop state, `vreg_active` or `dbg_clk_en`.
- R11: A stop strobe that arrives while stopped or restoring is ignored.
- R12: Synchronous reset puts the block in run with the clock enables, debug clock and regulator high, and `illegal_rst` and `exit_strobe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Core executed a stop instruction (one-cycle strobe) |
| cfg_stop_en | input | 1 | Stop instruction permitted |
| cfg_dbg_en | input | 1 | Debug interface enabled |
| cfg_lvd_en | input | 1 | Low-voltage detect enabled |
| cfg_lvd_stop | input | 1 | Low-voltage detect kept active in stop |
| cfg_deep_sel | input | 1 | Partial power-down (deep stop) select |
| wake_irq | input | NUM_WAKE | Pending wakeup interrupt lines |
| wake_mask | input | NUM_WAKE | Per-line wakeup enable |
| deep_wake | input | 1 | Dedicated deep-stop wake input |
| pin_rst | input | 1 | Reset pin request that ends a stop |
| bus_clk_en | output | 1 | Bus clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| dbg_clk_en | output | 1 | Debug interface clock enable |
| vreg_active | output | 1 | Voltage regulator held in full-power mode |
| illegal_rst | output | 1 | Illegal-opcode reset request pulse |
| stop_state | output | 2 | 0 run, 1 shallow, 2 deep, 3 restore |
| exit_strobe | output | 1 | One-cycle pulse on return to run |
| exit_cause | output | 2 | 0 reset, 1 interrupt, 2 deep wake, 3 none yet |
| exit_src | output | SRC_W | Index of the waking interrupt line |
| deep_exit_flag | output | 1 | Last exit came from deep stop |

## Verification
The assertions take for granted that `stop_req` is a single-cycle strobe. They also assume that wake inputs are not held across the restore cycle, so that every accepted wake leads to one clean return to run. The bench drops every wake input in the restore cycle. It raises `stop_req` only for one cycle at a time, and during a stop it raises it at random to check that the strobe is ignored. Inside a dwell period, unmasked interrupt lines are driven only as `wake_irq & ~wake_mask` in shallow stop, so nothing there can legally wake the block. In deep stop the lines are fully random.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SHALLOW = 2'd1,
        ST_DEEP    = 2'd2,
        ST_RESTORE = 2'd3
    } pstate_e;

    typedef enum logic [1:0] {
        CAUSE_RESET    = 2'd0,
        CAUSE_IRQ      = 2'd1,
        CAUSE_DEEPWAKE = 2'd2,
        CAUSE_NONE     = 2'd3
    } cause_e;

    typedef struct packed {
        logic deep;
        logic keep_vreg;
        logic keep_dbg;
    } stop_mode_t;

    // Priority decode: debug first, then low-voltage detect, then depth select.
    function automatic stop_mode_t pick_mode(input logic dbg, input logic lvd_en,
                                             input logic lvd_stop, input logic deep_sel);
        stop_mode_t m;
        m = '0;
        if (dbg) begin
            m.keep_dbg  = 1'b1;
            m.keep_vreg = 1'b1;
        end else if (lvd_en && lvd_stop) begin
            m.keep_vreg = 1'b1;
        end else begin
            m.deep = deep_sel;
        end
        return m;
    endfunction

endpackage

// File: rtl/stopctl_decode.sv
module stopctl_decode
    import stopctl_pkg::*;
(
    input  logic       stop_en,
    input  logic       dbg_en,
    input  logic       lvd_en,
    input  logic       lvd_stop,
    input  logic       deep_sel,
    output logic       illegal,
    output stop_mode_t mode
);

    always_comb begin
        illegal = !stop_en;
        mode    = pick_mode(dbg_en, lvd_en, lvd_stop, deep_sel);
    end

    // R3: low-voltage detect in stop never yields deep stop
    always_comb begin
        if (lvd_en && lvd_stop)
            a_r3_no_deep_with_lvd: assert (!mode.deep);
    end

    // R2: debug enabled never yields deep stop
    always_comb begin
        if (dbg_en)
            a_r2_no_deep_with_dbg: assert (!mode.deep && mode.keep_dbg);
    end

endmodule

// File: rtl/stopctl_wake.sv
module stopctl_wake
    import stopctl_pkg::*;
#(
    parameter int NUM_WAKE = 8,
    localparam int SRC_W   = (NUM_WAKE > 1) ? $clog2(NUM_WAKE) : 1
) (
    input  logic                in_shallow,
    input  logic                in_deep,
    input  logic                pin_rst,
    input  logic [NUM_WAKE-1:0] irq,
    input  logic [NUM_WAKE-1:0] mask,
    input  logic                deep_wake,
    output logic                hit,
    output cause_e              cause,
    output logic [SRC_W-1:0]    src
);

    logic [NUM_WAKE-1:0] live;
    logic [SRC_W-1:0]    low_idx;

    assign live = irq & mask;

    // Lowest set index wins: scan from the top so the last write is the lowest.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_WAKE - 1; i >= 0; i--) begin
            if (live[i]) low_idx = SRC_W'(i);
        end
    end

    always_comb begin
        hit   = 1'b0;
        cause = CAUSE_NONE;
        src   = '0;
        if (in_shallow || in_deep) begin
            if (pin_rst) begin
                hit   = 1'b1;
                cause = CAUSE_RESET;
            end else if (in_shallow && (|live)) begin
                hit   = 1'b1;
                cause = CAUSE_IRQ;
                src   = low_idx;
            end else if (in_deep && deep_wake) begin
                hit   = 1'b1;
                cause = CAUSE_DEEPWAKE;
            end
        end
    end

    // R8: interrupt lines never report a wake out of deep stop
    always_comb begin
        if (in_deep && hit)
            a_r8_deep_no_irq_cause: assert (cause != CAUSE_IRQ);
    end

    // R7: the reset pin always wins while stopped
    always_comb begin
        if ((in_shallow || in_deep) && pin_rst)
            a_r7_reset_first: assert (hit && cause == CAUSE_RESET);
    end

endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
    import stopctl_pkg::*;
#(
    parameter int NUM_WAKE = 8,
    localparam int SRC_W   = (NUM_WAKE > 1) ? $clog2(NUM_WAKE) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stop_req,
    input  logic                cfg_stop_en,
    input  logic                cfg_dbg_en,
    input  logic                cfg_lvd_en,
    input  logic                cfg_lvd_stop,
    input  logic                cfg_deep_sel,
    input  logic [NUM_WAKE-1:0] wake_irq,
    input  logic [NUM_WAKE-1:0] wake_mask,
    input  logic                deep_wake,
    input  logic                pin_rst,
    output logic                bus_clk_en,
    output logic                cpu_clk_en,
    output logic                dbg_clk_en,
    output logic                vreg_active,
    output logic                illegal_rst,
    output logic [1:0]          stop_state,
    output logic                exit_strobe,
    output logic [1:0]          exit_cause,
    output logic [SRC_W-1:0]    exit_src,
    output logic                deep_exit_flag
);

    pstate_e          state_q;
    stop_mode_t       mode_q;
    stop_mode_t       dec_mode;
    logic             dec_illegal;
    logic             wk_hit;
    cause_e           wk_cause;
    logic [SRC_W-1:0] wk_src;
    cause_e           cause_q;
    cause_e           pend_cause_q;
    logic [SRC_W-1:0] pend_src_q;
    logic             pend_deep_q;
    logic             stopped;

    stopctl_decode u_decode (
        .stop_en  (cfg_stop_en),
        .dbg_en   (cfg_dbg_en),
        .lvd_en   (cfg_lvd_en),
        .lvd_stop (cfg_lvd_stop),
        .deep_sel (cfg_deep_sel),
        .illegal  (dec_illegal),
        .mode     (dec_mode)
    );

    stopctl_wake #(.NUM_WAKE(NUM_WAKE)) u_wake (
        .in_shallow (state_q == ST_SHALLOW),
        .in_deep    (state_q == ST_DEEP),
        .pin_rst    (pin_rst),
        .irq        (wake_irq),
        .mask       (wake_mask),
        .deep_wake  (deep_wake),
        .hit        (wk_hit),
        .cause      (wk_cause),
        .src        (wk_src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_RUN;
            mode_q         <= '0;
            illegal_rst    <= 1'b0;
            exit_strobe    <= 1'b0;
            cause_q        <= CAUSE_NONE;
            exit_src       <= '0;
            deep_exit_flag <= 1'b0;
            pend_cause_q   <= CAUSE_NONE;
            pend_src_q     <= '0;
            pend_deep_q    <= 1'b0;
        end else begin
            illegal_rst <= 1'b0;
            exit_strobe <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (stop_req) begin
                        if (dec_illegal) begin
                            illegal_rst <= 1'b1;
                        end else begin
                            mode_q  <= dec_mode;
                            state_q <= dec_mode.deep ? ST_DEEP : ST_SHALLOW;
                        end
                    end
                end
                ST_SHALLOW, ST_DEEP: begin
                    if (wk_hit) begin
                        pend_cause_q <= wk_cause;
                        pend_src_q   <= wk_src;
                        pend_deep_q  <= (state_q == ST_DEEP);
                        state_q      <= ST_RESTORE;
                    end
                end
                ST_RESTORE: begin
                    state_q        <= ST_RUN;
                    exit_strobe    <= 1'b1;
                    cause_q        <= pend_cause_q;
                    exit_src       <= pend_src_q;
                    deep_exit_flag <= pend_deep_q;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    assign stopped     = (state_q == ST_SHALLOW) || (state_q == ST_DEEP);
    assign bus_clk_en  = !stopped;
    assign cpu_clk_en  = !stopped;
    assign dbg_clk_en  = !stopped || (state_q == ST_SHALLOW && mode_q.keep_dbg);
    assign vreg_active = !stopped || (state_q == ST_SHALLOW && mode_q.keep_vreg);
    assign stop_state  = state_q;
    assign exit_cause  = cause_q;

    // R1: illegal-opcode request is a single-cycle pulse and leaves run untouched
    a_r1_illegal_pulse: assert property (@(posedge clk) disable iff (rst)
        illegal_rst |=> !illegal_rst);
    a_r1_illegal_in_run: assert property (@(posedge clk) disable iff (rst)
        illegal_rst |-> (state_q == ST_RUN && bus_clk_en));

    // R5: no bus or CPU clock while stopped
    a_r5_clocks_gated: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHALLOW || state_q == ST_DEEP) |-> (!bus_clk_en && !cpu_clk_en));

    // R9: the exit strobe always follows a restore cycle
    a_r9_restore_first: assert property (@(posedge clk) disable iff (rst)
        exit_strobe |-> ($past(state_q) == ST_RESTORE && state_q == ST_RUN));
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
        exit_strobe |=> !exit_strobe);

    // R8: deep stop holds without reset pin or dedicated wake
    a_r8_deep_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEEP && !pin_rst && !deep_wake) |=> state_q == ST_DEEP);

    // R10: captured mode is frozen while stopped
    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |=> $stable(mode_q));

    // R11: a stop strobe never moves the block straight from one stop to another
    a_r11_no_restop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESTORE) |=> state_q == ST_RUN);

endmodule

// File: tb/stop_mode_ctrl_bench.sv
module stop_mode_ctrl_bench;

    localparam int NW = 8;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst;
    logic stop_req, cfg_stop_en, cfg_dbg_en, cfg_lvd_en, cfg_lvd_stop, cfg_deep_sel;
    logic [NW-1:0] wake_irq, wake_mask;
    logic deep_wake, pin_rst;
    logic bus_clk_en, cpu_clk_en, dbg_clk_en, vreg_active, illegal_rst;
    logic [1:0] stop_state;
    logic exit_strobe;
    logic [1:0] exit_cause;
    logic [SW-1:0] exit_src;
    logic deep_exit_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    stop_mode_ctrl #(.NUM_WAKE(NW)) u_stop_mode_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req),
        .cfg_stop_en(cfg_stop_en), .cfg_dbg_en(cfg_dbg_en), .cfg_lvd_en(cfg_lvd_en),
        .cfg_lvd_stop(cfg_lvd_stop), .cfg_deep_sel(cfg_deep_sel),
        .wake_irq(wake_irq), .wake_mask(wake_mask), .deep_wake(deep_wake), .pin_rst(pin_rst),
        .bus_clk_en(bus_clk_en), .cpu_clk_en(cpu_clk_en), .dbg_clk_en(dbg_clk_en),
        .vreg_active(vreg_active), .illegal_rst(illegal_rst), .stop_state(stop_state),
        .exit_strobe(exit_strobe), .exit_cause(exit_cause), .exit_src(exit_src),
        .deep_exit_flag(deep_exit_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Reference decode: 1 shallow, 2 deep
    function automatic int ref_state(bit dbg, bit le, bit ls, bit ds);
        if (dbg) return 1;
        if (le && ls) return 1;
        return ds ? 2 : 1;
    endfunction

    function automatic int ref_vreg(bit dbg, bit le, bit ls);
        return (dbg || (le && ls)) ? 1 : 0;
    endfunction

    function automatic int ref_low(logic [NW-1:0] v);
        for (int i = 0; i < NW; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic idle_inputs();
        stop_req = 0; wake_irq = '0; wake_mask = '0; deep_wake = 0; pin_rst = 0;
    endtask

    // kind: 0 reset pin, 1 irq, 2 deep wake, 3 reset pin with irq and deep wake
    task automatic run_stop(bit dbg, bit le, bit ls, bit ds, int dwell, int kind);
        int es, ev, ed, ecause, esrc;
        logic [NW-1:0] irqv, maskv;
        cfg_stop_en = 1; cfg_dbg_en = dbg; cfg_lvd_en = le; cfg_lvd_stop = ls; cfg_deep_sel = ds;
        stop_req = 1;
        step();
        stop_req = 0;
        es = ref_state(dbg, le, ls, ds);
        ev = ref_vreg(dbg, le, ls);
        ed = dbg;
        chk(dbg ? "R2 state" : ((le && ls) ? "R3 state" : "R4 state"), stop_state, es);
        chk(dbg ? "R2 vreg" : ((le && ls) ? "R3 vreg" : "R4 vreg"), vreg_active, ev);
        chk("R5 bus clk off", bus_clk_en, 0);
        chk("R5 cpu clk off", cpu_clk_en, 0);
        chk(dbg ? "R2 dbg clk" : "R5 dbg clk", dbg_clk_en, ed);
        for (int c = 0; c < dwell; c++) begin
            cfg_stop_en = 1'($urandom); cfg_dbg_en = 1'($urandom); cfg_lvd_en = 1'($urandom);
            cfg_lvd_stop = 1'($urandom); cfg_deep_sel = 1'($urandom);
            stop_req = 1'($urandom);
            wake_mask = NW'($urandom);
            if (es == 1) begin
                wake_irq = NW'($urandom) & ~wake_mask;
                deep_wake = 1'($urandom);
            end else begin
                wake_irq = NW'($urandom);
                deep_wake = 0;
            end
            step();
            chk(es == 2 ? "R8 deep holds" : "R11 state holds", stop_state, es);
            chk("R10 vreg held", vreg_active, ev);
            chk("R10 dbg clk held", dbg_clk_en, ed);
        end
        idle_inputs();
        if (es == 2 && kind == 1) kind = 2;
        if (es == 1 && kind == 2) kind = 1;
        irqv = NW'($urandom) | NW'(1 << ($urandom % NW));
        maskv = irqv | NW'($urandom);
        esrc = 0;
        case (kind)
            0: begin pin_rst = 1; ecause = 0; end
            1: begin wake_irq = irqv; wake_mask = maskv; ecause = 1; esrc = ref_low(irqv & maskv); end
            2: begin deep_wake = 1; ecause = 2; end
            default: begin pin_rst = 1; deep_wake = 1; wake_irq = irqv; wake_mask = maskv; ecause = 0; end
        endcase
        step();
        idle_inputs();
        chk("R9 restore state", stop_state, 3);
        chk("R9 clocks back", bus_clk_en & cpu_clk_en, 1);
        chk("R9 no strobe yet", exit_strobe, 0);
        step();
        chk("R9 run", stop_state, 0);
        chk("R9 strobe", exit_strobe, 1);
        chk(ecause == 0 ? "R7 cause" : (ecause == 1 ? "R6 cause" : "R8 cause"), exit_cause, ecause);
        if (ecause == 1) chk("R6 source", exit_src, esrc);
        chk("R8 deep flag", deep_exit_flag, es == 2 ? 1 : 0);
        step();
        chk("R9 strobe single", exit_strobe, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        rst = 1;
        idle_inputs();
        cfg_stop_en = 0; cfg_dbg_en = 0; cfg_lvd_en = 0; cfg_lvd_stop = 0; cfg_deep_sel = 0;
        step(); step();
        rst = 0;
        // R12 reset state
        chk("R12 state", stop_state, 0);
        chk("R12 clocks", bus_clk_en & cpu_clk_en & dbg_clk_en & vreg_active, 1);
        chk("R12 strobes", illegal_rst | exit_strobe, 0);

        // R1 illegal stop
        cfg_stop_en = 0; cfg_deep_sel = 1;
        stop_req = 1;
        step();
        stop_req = 0;
        chk("R1 illegal pulse", illegal_rst, 1);
        chk("R1 stays run", stop_state, 0);
        chk("R1 clocks on", bus_clk_en & cpu_clk_en, 1);
        step();
        chk("R1 pulse ends", illegal_rst, 0);

        // Directed corners
        run_stop(1, 0, 0, 1, 3, 1);   // R2 debug beats deep select
        run_stop(0, 1, 1, 1, 3, 1);   // R3 downgrade of deep request
        run_stop(0, 1, 0, 0, 2, 1);   // R4 plain shallow
        run_stop(0, 0, 1, 1, 4, 2);   // R4 deep, R8 deep wake
        run_stop(0, 0, 0, 1, 2, 0);   // R7 reset pin out of deep
        run_stop(0, 0, 0, 0, 2, 3);   // R7 reset pin beats irq in shallow
        run_stop(0, 0, 0, 1, 2, 3);   // R7 reset pin beats deep wake

        // R6 lowest index wins: lines 5 and 2 enabled
        cfg_stop_en = 1; cfg_dbg_en = 0; cfg_lvd_en = 0; cfg_lvd_stop = 0; cfg_deep_sel = 0;
        stop_req = 1; step(); stop_req = 0;
        wake_irq = 8'b0010_0101; wake_mask = 8'b0010_0100;
        step(); idle_inputs(); step();
        chk("R6 priority source", exit_src, 2);
        chk("R6 priority cause", exit_cause, 1);

        // Constrained random
        for (int n = 0; n < 300; n++) begin
            if (($urandom % 6) == 0) begin
                cfg_stop_en = 0;
                stop_req = 1; step(); stop_req = 0;
                chk("R1 random illegal", illegal_rst, 1);
                chk("R1 random run", stop_state, 0);
                step();
            end else begin
                run_stop(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                         int'($urandom % 6), int'($urandom % 4));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule